// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns a 48 MHz reference clock into the oversampling strobe for a UART. The strobe rate is 16 times the serial bit rate. The strobe is a one-cycle pulse on `tick_o`. The divisor has two parts: a 14-bit integer code and a 3-bit selector that adds a fraction in eighths. For an integer code of 2 or more, the mean spacing between ticks is integer + fraction/8 reference cycles. The block reaches this by mixing spacings of floor and floor+1 cycles under control of a 3-bit phase accumulator. Across the 14-bit range this covers bit rates from about 183 baud up to 3 Mbaud.

Two integer codes are reserved for the fastest rates, and both ignore the fraction selector:
- Code 0 gives a tick on every reference cycle, which is 3 Mbaud.
- Code 1 gives ticks spaced 1 and 2 cycles in turn, a mean of 1.5 cycles, which is 2 Mbaud.

A new divisor is captured when `load_i` is high. It is held until the running interval finishes. It then takes over with the accumulator cleared, so the serial stream never sees a shortened or stretched odd period.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_i` is high, `tick_o` is low. After release, a tick occurs on the first clock edge, and the reset divisor (integer 26, fraction 0) then sets every spacing to 26 cycles.
- R2: `tick_o` is a single-cycle pulse. Whenever the current spacing is 2 or more cycles, it is never high on two consecutive cycles.
- R3: For an integer code N >= 2 with fraction selector 0, every tick spacing is exactly N cycles.
- R4: For an integer code N >= 2 with fraction selector F (F in 0..7, weight F/8):
  - The accumulator starts at 0 when the divisor is applied.
  - For each spacing, the 3-bit accumulator adds F. The spacing is N+1 when that sum carries past 7, and N otherwise.
  - As a result, any 8 consecutive spacings total 8N+F cycles.
- R5: Integer code 0 produces a tick on every cycle, whatever the fraction selector holds.
- R6: Integer code 1 produces spacings of 1, 2, 1, 2, and so on, starting with 1, whatever the fraction selector holds.
- R7: `load_i` high at a clock edge captures both divisor fields. The first tick that comes strictly after that edge marks the switch. Every spacing after that tick follows the new divisor, starting from a cleared accumulator.
- R8: Changes to the divisor inputs while `load_i` is low have no effect on the tick spacing.
- R9: Large integer codes are counted exactly, with spacings up to 2^14 cycles (for example, N = 9000 with F = 5 gives 8 spacings totalling 72005 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 48 MHz reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| div_int_i | input | 14 | Integer divisor code (0 and 1 are the reserved fast rates) |
| div_frac_i | input | 3 | Fraction selector in eighths |
| load_i | input | 1 | Capture strobe for both divisor fields |
| tick_o | output | 1 | Registered one-cycle tick at 16x the bit rate |

## Verification
The assertions assume `rst_i` is held for at least one edge at start-up. They place no limits on when `load_i` may pulse, and they accept any divisor code, including 0 and 1. They do take for granted that a load landing exactly on an interval boundary is deferred to the next boundary rather than applied at once.

The stimulus always issues `load_i` for a single cycle on the cycle that follows an observed tick. It then waits for the next tick before measuring. This keeps every measured spacing inside a window whose accumulator phase is known from the requirements. The stimulus sweeps every fraction with integer codes 0 to 5, and adds two large codes.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Rate class derived from the integer divisor code
  typedef enum logic [1:0] {
    RATE_EVERY_CYCLE = 2'd0,  // code 0: one tick per reference cycle
    RATE_ONE_HALF    = 2'd1,  // code 1: mean spacing of 1.5 cycles
    RATE_FRACTIONAL  = 2'd2   // code >= 2: integer plus eighths
  } rate_mode_e;

  function automatic rate_mode_e classify_code(input int unsigned code);
    if (code == 0)      return RATE_EVERY_CYCLE;
    else if (code == 1) return RATE_ONE_HALF;
    else                return RATE_FRACTIONAL;
  endfunction

endpackage

// File: rtl/baud_cfg_hold.sv
// Holds the active divisor and a pending one that waits for the interval boundary.
module baud_cfg_hold #(
  parameter int INT_W    = 14,
  parameter int FRAC_W   = 3,
  parameter int RST_INT  = 26,
  parameter int RST_FRAC = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              load_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic              reload_i,
  output logic [INT_W-1:0]  sel_int_o,
  output logic [FRAC_W-1:0] sel_frac_o,
  output logic              fresh_o
);

  logic [INT_W-1:0]  pend_int_q, act_int_q;
  logic [FRAC_W-1:0] pend_frac_q, act_frac_q;
  logic              pend_valid_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_int_q   <= '0;
      pend_frac_q  <= '0;
      pend_valid_q <= 1'b0;
      act_int_q    <= INT_W'(RST_INT);
      act_frac_q   <= FRAC_W'(RST_FRAC);
    end else begin
      if (reload_i && pend_valid_q) begin
        act_int_q  <= pend_int_q;
        act_frac_q <= pend_frac_q;
      end
      if (load_i) begin
        pend_int_q   <= int_i;
        pend_frac_q  <= frac_i;
        pend_valid_q <= 1'b1;
      end else if (reload_i) begin
        pend_valid_q <= 1'b0;
      end
    end
  end

  // The divisor that governs the interval starting at this boundary
  always_comb begin
    if (pend_valid_q) begin
      sel_int_o  = pend_int_q;
      sel_frac_o = pend_frac_q;
    end else begin
      sel_int_o  = act_int_q;
      sel_frac_o = act_frac_q;
    end
    fresh_o = pend_valid_q;
  end

  // R7
  load_capture_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> (pend_valid_q && pend_int_q == $past(int_i) && pend_frac_q == $past(frac_i)));

endmodule

// File: rtl/baud_phase_acc.sv
// Maps the divisor code to an integer/eighths pair and picks the next interval length.
module baud_phase_acc
  import baud_gen_pkg::*;
#(
  parameter int INT_W  = 14,
  parameter int FRAC_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              reload_i,
  input  logic              fresh_i,
  input  logic [INT_W-1:0]  int_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [INT_W:0]    period_o
);

  localparam logic [FRAC_W-1:0] HALF_STEP = {1'b1, {(FRAC_W-1){1'b0}}};

  rate_mode_e        mode;
  logic [INT_W-1:0]  eff_int;
  logic [FRAC_W-1:0] eff_frac;
  logic [FRAC_W-1:0] acc_q, acc_base;
  logic [FRAC_W:0]   sum;
  logic              carry;

  always_comb begin
    mode = classify_code(32'(int_i));
    case (mode)
      RATE_EVERY_CYCLE: begin
        eff_int  = INT_W'(1);
        eff_frac = '0;
      end
      RATE_ONE_HALF: begin
        eff_int  = INT_W'(1);
        eff_frac = HALF_STEP;
      end
      default: begin
        eff_int  = int_i;
        eff_frac = frac_i;
      end
    endcase
    acc_base = fresh_i ? '0 : acc_q;
    sum      = {1'b0, acc_base} + {1'b0, eff_frac};
    carry    = sum[FRAC_W];
    period_o = {1'b0, eff_int} + {{INT_W{1'b0}}, carry};
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)         acc_q <= '0;
    else if (reload_i) acc_q <= sum[FRAC_W-1:0];
  end

  // R4
  period_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int_i > INT_W'(1)) |-> (period_o == {1'b0, int_i} || period_o == {1'b0, int_i} + (INT_W+1)'(1)));
  // R5
  full_rate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int_i == '0) |-> (period_o == (INT_W+1)'(1)));
  // R6
  half_rate_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (int_i == INT_W'(1)) |-> (period_o == (INT_W+1)'(1) || period_o == (INT_W+1)'(2)));

endmodule

// File: rtl/baud_down_counter.sv
// Counts down each interval and emits the registered tick at its end.
module baud_down_counter #(
  parameter int CNT_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             reload_o,
  output logic             tick_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  assign reload_o = (cnt_q == CNT_W'(1));
  assign tick_o   = tick_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q  <= CNT_W'(1);
      tick_q <= 1'b0;
    end else if (reload_o) begin
      cnt_q  <= period_i;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q - CNT_W'(1);
      tick_q <= 1'b0;
    end
  end

  // R2
  period_nonzero_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    reload_o |-> (period_i != '0));
  // R2
  no_back_to_back_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (reload_o && period_i >= CNT_W'(2)) |=> ##1 !tick_q);

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int INT_W    = 14,
  parameter int FRAC_W   = 3,
  parameter int RST_INT  = 26,
  parameter int RST_FRAC = 0
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [INT_W-1:0]  div_int_i,
  input  logic [FRAC_W-1:0] div_frac_i,
  input  logic              load_i,
  output logic              tick_o
);

  localparam int CNT_W = INT_W + 1;

  logic [INT_W-1:0]  sel_int;
  logic [FRAC_W-1:0] sel_frac;
  logic              fresh;
  logic              reload;
  logic [CNT_W-1:0]  period;

  baud_cfg_hold #(
    .INT_W(INT_W), .FRAC_W(FRAC_W), .RST_INT(RST_INT), .RST_FRAC(RST_FRAC)
  ) cfg_i (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i),
    .int_i(div_int_i), .frac_i(div_frac_i), .reload_i(reload),
    .sel_int_o(sel_int), .sel_frac_o(sel_frac), .fresh_o(fresh)
  );

  baud_phase_acc #(.INT_W(INT_W), .FRAC_W(FRAC_W)) acc_i (
    .clk_i(clk_i), .rst_i(rst_i), .reload_i(reload), .fresh_i(fresh),
    .int_i(sel_int), .frac_i(sel_frac), .period_o(period)
  );

  baud_down_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk_i(clk_i), .rst_i(rst_i), .period_i(period),
    .reload_o(reload), .tick_o(tick_o)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk_i)
    $past(rst_i) |-> !tick_o);

endmodule

// File: tb/baud_tick_gen_tb_top.sv
`timescale 1ns/1ps
module baud_tick_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] div_int = '0;
  logic [2:0]  div_frac = '0;
  logic        load = 1'b0;
  logic        tick;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  baud_tick_gen dut_i (
    .clk_i(clk), .rst_i(rst), .div_int_i(div_int), .div_frac_i(div_frac),
    .load_i(load), .tick_o(tick)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_tick(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!tick && gap < 20000);
  endtask

  // Expected spacing k from a cleared accumulator (R3..R6)
  function automatic int exp_gap(input int i, input int f, input int k);
    int ei, ef, acc, s, g;
    ei = i; ef = f;
    if (i == 0) begin ei = 1; ef = 0; end
    else if (i == 1) begin ei = 1; ef = 4; end
    acc = 0; g = ei;
    for (int n = 0; n <= k; n++) begin
      s = acc + ef;
      g = ei + ((s >= 8) ? 1 : 0);
      acc = s % 8;
    end
    return g;
  endfunction

  function automatic string tag_of(input int i, input int f);
    if (i == 0) return "R5 R7";
    if (i == 1) return "R6 R7";
    if (i > 1000) return "R9 R7";
    if (f == 0) return "R3 R7";
    return "R4 R7";
  endfunction

  // Controlled load right after a tick, then compare ngaps spacings
  task automatic run_cfg(input int i, input int f, input int ngaps);
    int g, tot;
    wait_tick(g);
    div_int = 14'(i); div_frac = 3'(f); load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    wait_tick(g);
    tot = 0;
    for (int k = 0; k < ngaps; k++) begin
      wait_tick(g);
      tot += g;
      check(tag_of(i, f), g, exp_gap(i, f, k));
      if (i >= 2) check("R2 width", (g >= 2) ? 1 : 0, 1);
    end
    if (i >= 2 && ngaps == 8) check("R4 total", tot, 8 * i + f);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    check("R1 reset", int'(tick), 0);
    @(negedge clk);
    check("R1 reset", int'(tick), 0);
    rst = 1'b0;
    wait_tick(g);
    check("R1 first", g, 1);
    for (int k = 0; k < 2; k++) begin
      wait_tick(g);
      check("R1 default", g, 26);
    end

    for (int i = 0; i <= 5; i++)
      for (int f = 0; f <= 7; f++)
        run_cfg(i, f, 8);

    // R8: fields change without load, spacing continues unchanged
    run_cfg(4, 3, 8);
    div_int = 14'd7; div_frac = 3'd0;
    for (int k = 0; k < 8; k++) begin
      wait_tick(g);
      check("R8 ignored", g, exp_gap(4, 3, k));
    end

    // R7: reload the same divisor mid-stream; accumulator restarts at 0
    run_cfg(2, 4, 4);
    run_cfg(2, 4, 4);

    run_cfg(300, 3, 8);
    run_cfg(9000, 5, 8);
    run_cfg(3, 0, 4);

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule